// File: doc/BRIEF.md
# Virtual Address Translator with Lookaside Buffer

This block turns a 14-bit virtual address into a 12-bit physical address for a small paged memory system with 64-byte pages. Each request is first looked up in a 16-entry, 4-set by 4-way lookaside buffer. When the buffer has no matching entry, the block reads its own page table, which is held in registers and indexed by the 8-bit virtual page number. A successful table read refills the buffer, so later requests to the same page are answered from the buffer.

Every response reports whether it came from the buffer. It also reports whether the page was not resident (a page fault) or whether the access type or privilege level was refused (a protection fault). Software loads page-table entries through a write port. A flush input empties the buffer, for example on a context switch. Writing an entry also drops any buffered copy of that page. Moving pages to and from backing storage, handling faults and caching data are left to other blocks.

Top module: `vat_translator`

## Requirements
- R1: On a response with no fault, the low 6 bits of the physical address equal the low 6 bits of the request's virtual address, and the upper 6 bits are the PPN from the page-table entry (bits [5:0] of an entry).
- R2: A request whose page is held in the buffer is answered in the cycle after it is accepted, with rsp_hit=1.
- R3: A request that misses the buffer drops req_ready for one cycle and is answered two cycles after acceptance with rsp_hit=0. A later request to the same resident page then hits.
- R4: An entry whose valid bit (bit 10) is 0 gives rsp_fault=1, rsp_prot=0, rsp_hit=0 and a physical address of zero. The buffer is not refilled, so a repeated access misses and faults again.
- R5: Entry bits 6, 7 and 8 grant read, write and execute. Bit 9 makes the page kernel-only. req_acc encodes 0=read, 1=write, 2=execute; code 3 is always refused. A refused access on a valid page gives rsp_prot=1, rsp_fault=0 and a zero address.
- R6: The buffer set is VPN[1:0] and the tag is VPN[7:2]. A refill goes to the lowest-numbered invalid way of its set. If the set is full, the refill goes to the way named by that set's pointer. The pointer starts at 0, advances by one only after such a replacement, and is not changed by a flush.
- R7: Asserting tlb_flush for one cycle invalidates every buffer entry, so the next request to any page misses.
- R8: Writing a page-table entry invalidates the buffered copy of that page. The next access misses and returns the new translation.
- R9: After reset, rsp_valid=0, req_ready=1 and every page-table entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_va | input | 14 | Virtual address |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 execute |
| req_user | input | 1 | 1 = user mode, 0 = kernel mode |
| rsp_valid | output | 1 | Response present (one cycle) |
| rsp_pa | output | 12 | Physical address, zero on any fault |
| rsp_hit | output | 1 | Answer came from the buffer |
| rsp_fault | output | 1 | Page not resident |
| rsp_prot | output | 1 | Access refused by permissions |
| pt_we | input | 1 | Page-table write strobe |
| pt_idx | input | 8 | Page-table entry index (VPN) |
| pt_wdata | input | 11 | Entry: [10] valid, [9] kernel-only, [8] exec, [7] write, [6] read, [5:0] PPN |
| tlb_flush | input | 1 | Invalidate the whole buffer |

## Verification
Several rules are checked by properties on every cycle: the fixed answer latency of hits, the single stall cycle followed by a miss answer, the zero address and exclusive flags on faults, offset pass-through against the accepted address, and the absence of hits right after a flush. Only the bench scenarios can show which translation comes back, how victims are chosen in a full set, that a rewritten entry is fetched fresh, and that faulting pages are never cached. The bench predicts these with its own model of the buffer and table.

// File: rtl/vat_pkg.sv
// Shared sizes and types for the virtual address translator.
// Assumes power-of-two set and way counts.
package vat_pkg;
    parameter int VA_W  = 14;
    parameter int PA_W  = 12;
    parameter int OFF_W = 6;
    parameter int SETS  = 4;
    parameter int WAYS  = 4;

    localparam int VPN_W = VA_W - OFF_W;
    localparam int PPN_W = PA_W - OFF_W;
    localparam int SET_W = $clog2(SETS);
    localparam int TAG_W = VPN_W - SET_W;
    localparam int WAY_W = $clog2(WAYS);
    localparam int PT_DEPTH = 1 << VPN_W;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2
    } acc_e;

    // Page-table entry; packed order fixes the bit layout of the write port.
    typedef struct packed {
        logic             valid;
        logic             kern_only;
        logic             can_x;
        logic             can_w;
        logic             can_r;
        logic [PPN_W-1:0] ppn;
    } pte_t;

    typedef struct packed {
        logic             valid;
        logic [TAG_W-1:0] tag;
        pte_t             pte;
    } tlb_ent_t;
endpackage

// File: rtl/vat_page_table.sv
// Register-held single-level page table, one entry per virtual page.
// Write port is synchronous; read port is combinational. Reset clears all entries.
module vat_page_table
    import vat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [VPN_W-1:0] wr_idx,
    input  pte_t             wr_pte,
    input  logic [VPN_W-1:0] rd_idx,
    output pte_t             rd_pte
);
    pte_t table_q [PT_DEPTH];

    // Store software-written entries; reset marks every page non-resident.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PT_DEPTH; i++) table_q[i] <= '0;
        end else if (wr_en) begin
            table_q[wr_idx] <= wr_pte;
        end
    end

    // Present the entry selected by the walk.
    assign rd_pte = table_q[rd_idx];
endmodule

// File: rtl/vat_perm_check.sv
// Combinational permission check of one entry against an access.
// Assumes access code 3 is never legal.
module vat_perm_check
    import vat_pkg::*;
(
    input  logic       ent_valid,
    input  logic       can_r,
    input  logic       can_w,
    input  logic       can_x,
    input  logic       kern_only,
    input  logic [1:0] acc,
    input  logic       user,
    output logic       allow
);
    logic type_ok;

    // Pick the right-bit for the requested access type.
    always_comb begin
        case (acc)
            ACC_READ:  type_ok = can_r;
            ACC_WRITE: type_ok = can_w;
            ACC_EXEC:  type_ok = can_x;
            default:   type_ok = 1'b0;
        endcase
    end

    assign allow = ent_valid && type_ok && !(user && kern_only);
endmodule

// File: rtl/vat_tlb.sv
// Set-associative lookaside buffer: combinational lookup, synchronous refill,
// single-page invalidate and full flush. Flush outranks invalidate and refill.
// Assumes the caller never refills a page that is already present.
module vat_tlb
    import vat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output pte_t             lk_pte,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  pte_t             fill_pte,
    input  logic             inv_en,
    input  logic [VPN_W-1:0] inv_vpn,
    input  logic             flush
);
    tlb_ent_t         ent_q [SETS][WAYS];
    logic [WAY_W-1:0] rr_q  [SETS];

    logic [SET_W-1:0] lk_set, fill_set, inv_set;
    logic [TAG_W-1:0] lk_tag, fill_tag, inv_tag;
    logic [WAYS-1:0]  way_match;
    logic             free_found;
    logic [WAY_W-1:0] free_way, victim;

    assign lk_set   = lk_vpn[SET_W-1:0];
    assign lk_tag   = lk_vpn[VPN_W-1:SET_W];
    assign fill_set = fill_vpn[SET_W-1:0];
    assign fill_tag = fill_vpn[VPN_W-1:SET_W];
    assign inv_set  = inv_vpn[SET_W-1:0];
    assign inv_tag  = inv_vpn[VPN_W-1:SET_W];

    // One tag comparator per way of the addressed set.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign way_match[w] = ent_q[lk_set][w].valid && (ent_q[lk_set][w].tag == lk_tag);
    end

    // Select the entry of the matching way.
    always_comb begin
        lk_pte = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (way_match[w]) lk_pte = ent_q[lk_set][w].pte;
        end
        lk_hit = |way_match;
    end

    // Find the lowest free way of the refill set.
    always_comb begin
        free_found = 1'b0;
        free_way   = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!ent_q[fill_set][w].valid) begin
                free_found = 1'b1;
                free_way   = WAY_W'(w);
            end
        end
        victim = free_found ? free_way : rr_q[fill_set];
    end

    // Update entries and replacement pointers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                rr_q[s] <= '0;
                for (int w = 0; w < WAYS; w++) ent_q[s][w] <= '0;
            end
        end else if (flush) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) ent_q[s][w].valid <= 1'b0;
            end
        end else begin
            if (inv_en) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (ent_q[inv_set][w].valid && ent_q[inv_set][w].tag == inv_tag)
                        ent_q[inv_set][w].valid <= 1'b0;
                end
            end
            if (fill_en) begin
                ent_q[fill_set][victim] <= '{valid: 1'b1, tag: fill_tag, pte: fill_pte};
                if (!free_found) rr_q[fill_set] <= rr_q[fill_set] + 1'b1;
            end
        end
    end
endmodule

// File: rtl/vat_translator.sv
// Top of the translator. A hit is answered one cycle after acceptance; a miss
// spends one stall cycle reading the page table, then answers and refills.
// Assumes software avoids writing the entry of a page being requested in the same cycle.
module vat_translator
    import vat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_va,
    input  logic [1:0]       req_acc,
    input  logic             req_user,
    output logic             rsp_valid,
    output logic [PA_W-1:0]  rsp_pa,
    output logic             rsp_hit,
    output logic             rsp_fault,
    output logic             rsp_prot,
    input  logic             pt_we,
    input  logic [VPN_W-1:0] pt_idx,
    input  logic [10:0]      pt_wdata,
    input  logic             tlb_flush
);
    logic             walking_q;
    logic [VA_W-1:0]  held_va_q;
    logic [1:0]       held_acc_q;
    logic             held_user_q;

    logic             accept, tlb_hit, hit_ok, walk_ok, fill_en, wr_hits_walk;
    logic [VPN_W-1:0] req_vpn, held_vpn;
    pte_t             tlb_pte, pt_pte, wr_pte;

    assign req_ready    = !walking_q;
    assign accept       = req_valid && req_ready;
    assign req_vpn      = req_va[VA_W-1:OFF_W];
    assign held_vpn     = held_va_q[VA_W-1:OFF_W];
    assign wr_pte       = pte_t'(pt_wdata);
    assign wr_hits_walk = pt_we && (pt_idx == held_vpn);
    assign fill_en      = walking_q && pt_pte.valid && !wr_hits_walk && !tlb_flush;

    vat_page_table u_pt (
        .clk(clk), .rst_n(rst_n),
        .wr_en(pt_we), .wr_idx(pt_idx), .wr_pte(wr_pte),
        .rd_idx(held_vpn), .rd_pte(pt_pte)
    );

    vat_tlb u_tlb (
        .clk(clk), .rst_n(rst_n),
        .lk_vpn(req_vpn), .lk_hit(tlb_hit), .lk_pte(tlb_pte),
        .fill_en(fill_en), .fill_vpn(held_vpn), .fill_pte(pt_pte),
        .inv_en(pt_we), .inv_vpn(pt_idx),
        .flush(tlb_flush)
    );

    vat_perm_check u_hit_perm (
        .ent_valid(tlb_pte.valid), .can_r(tlb_pte.can_r), .can_w(tlb_pte.can_w),
        .can_x(tlb_pte.can_x), .kern_only(tlb_pte.kern_only),
        .acc(req_acc), .user(req_user), .allow(hit_ok)
    );

    vat_perm_check u_walk_perm (
        .ent_valid(pt_pte.valid), .can_r(pt_pte.can_r), .can_w(pt_pte.can_w),
        .can_x(pt_pte.can_x), .kern_only(pt_pte.kern_only),
        .acc(held_acc_q), .user(held_user_q), .allow(walk_ok)
    );

    // Sequence requests and register the response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            walking_q   <= 1'b0;
            held_va_q   <= '0;
            held_acc_q  <= '0;
            held_user_q <= 1'b0;
            rsp_valid   <= 1'b0;
            rsp_pa      <= '0;
            rsp_hit     <= 1'b0;
            rsp_fault   <= 1'b0;
            rsp_prot    <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            if (walking_q) begin
                walking_q <= 1'b0;
                rsp_valid <= 1'b1;
                rsp_hit   <= 1'b0;
                rsp_fault <= !pt_pte.valid;
                rsp_prot  <= pt_pte.valid && !walk_ok;
                rsp_pa    <= walk_ok ? {pt_pte.ppn, held_va_q[OFF_W-1:0]} : '0;
            end else if (accept) begin
                if (tlb_hit) begin
                    rsp_valid <= 1'b1;
                    rsp_hit   <= 1'b1;
                    rsp_fault <= 1'b0;
                    rsp_prot  <= !hit_ok;
                    rsp_pa    <= hit_ok ? {tlb_pte.ppn, req_va[OFF_W-1:0]} : '0;
                end else begin
                    walking_q   <= 1'b1;
                    held_va_q   <= req_va;
                    held_acc_q  <= req_acc;
                    held_user_q <= req_user;
                end
            end
        end
    end
endmodule

// File: rtl/vat_translator_chk.sv
// Property checker for the translator, attached through bind.
module vat_translator_chk
    import vat_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic [VA_W-1:0] req_va,
    input logic            rsp_valid,
    input logic [PA_W-1:0] rsp_pa,
    input logic            rsp_hit,
    input logic            rsp_fault,
    input logic            rsp_prot,
    input logic            tlb_flush
);
    logic [OFF_W-1:0] last_off_q;

    // Remember the offset of the most recently accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) last_off_q <= '0;
        else if (req_valid && req_ready) last_off_q <= req_va[OFF_W-1:0];
    end

    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_fault && !rsp_prot |-> rsp_pa[OFF_W-1:0] == last_off_q); // R1
    AST_HIT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_hit |-> $past(req_valid && req_ready)); // R2
    AST_MISS_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> rsp_valid && !rsp_hit); // R3
    AST_FAULT_ZERO_PA: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && (rsp_fault || rsp_prot) |-> rsp_pa == '0); // R4
    AST_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault |-> !rsp_hit && !rsp_prot); // R4
    AST_FLUSH_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_hit |-> !$past(tlb_flush, 2)); // R7
endmodule

bind vat_translator vat_translator_chk chk_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_hit(rsp_hit),
    .rsp_fault(rsp_fault), .rsp_prot(rsp_prot), .tlb_flush(tlb_flush)
);

// File: tb/vat_translator_tb_top.sv
// Self-checking bench: directed corner cases, then seeded random traffic,
// compared with a bench-side model of the buffer and page table.
module vat_translator_tb_top;
    import vat_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [13:0] req_va = '0;
    logic [1:0]  req_acc = '0;
    logic        req_user = 1'b0;
    logic        rsp_valid;
    logic [11:0] rsp_pa;
    logic        rsp_hit, rsp_fault, rsp_prot;
    logic        pt_we = 1'b0;
    logic [7:0]  pt_idx = '0;
    logic [10:0] pt_wdata = '0;
    logic        tlb_flush = 1'b0;

    int errs = 0;
    int checks = 0;

    // Bench model state.
    pte_t       m_pt  [256];
    logic       m_v   [4][4];
    logic [5:0] m_tag [4][4];
    pte_t       m_pte [4][4];
    int         m_rr  [4];

    always #2 clk = ~clk;

    vat_translator dut_i (.*);

    task automatic check(input bit ok, input string req, input string what);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: %s", req, what);
        end
    endtask

    function automatic bit perm_ok(input pte_t p, input logic [1:0] acc, input logic user);
        bit t;
        case (acc)
            2'd0: t = p.can_r;
            2'd1: t = p.can_w;
            2'd2: t = p.can_x;
            default: t = 1'b0;
        endcase
        return p.valid && t && !(user && p.kern_only);
    endfunction

    function automatic pte_t mk(input bit v, input bit k, input bit x, input bit w,
                                input bit r, input logic [5:0] ppn);
        pte_t p;
        p.valid = v; p.kern_only = k; p.can_x = x; p.can_w = w; p.can_r = r; p.ppn = ppn;
        return p;
    endfunction

    task automatic pt_write(input logic [7:0] idx, input pte_t p);
        @(negedge clk);
        pt_we = 1'b1; pt_idx = idx; pt_wdata = p;
        @(negedge clk);
        pt_we = 1'b0;
        m_pt[idx] = p;
        for (int w = 0; w < 4; w++)
            if (m_v[idx[1:0]][w] && m_tag[idx[1:0]][w] == idx[7:2]) m_v[idx[1:0]][w] = 1'b0;
    endtask

    task automatic flush_tlb();
        @(negedge clk);
        tlb_flush = 1'b1;
        @(negedge clk);
        tlb_flush = 1'b0;
        for (int s = 0; s < 4; s++)
            for (int w = 0; w < 4; w++) m_v[s][w] = 1'b0;
    endtask

    // Issue one request, predict it from the model, check the response.
    task automatic translate(input logic [13:0] va, input logic [1:0] acc,
                             input logic user, input string req);
        logic [7:0]  vpn = va[13:6];
        logic [1:0]  set = vpn[1:0];
        bit          hit = 1'b0;
        bit          ok;
        pte_t        p = '0;
        logic [15:0] exp, act;
        int          vic;
        bit          found;
        for (int w = 0; w < 4; w++)
            if (m_v[set][w] && m_tag[set][w] == vpn[7:2]) begin hit = 1'b1; p = m_pte[set][w]; end
        if (!hit) p = m_pt[vpn];
        ok  = perm_ok(p, acc, user);
        exp = {1'b1, hit, !p.valid, p.valid && !ok, ok ? {p.ppn, va[5:0]} : 12'h000};
        if (!hit && p.valid) begin
            found = 1'b0; vic = 0;
            for (int w = 3; w >= 0; w--) if (!m_v[set][w]) begin found = 1'b1; vic = w; end
            if (!found) begin vic = m_rr[set]; m_rr[set] = (m_rr[set] + 1) % 4; end
            m_v[set][vic] = 1'b1; m_tag[set][vic] = vpn[7:2]; m_pte[set][vic] = p;
        end
        @(negedge clk);
        req_valid = 1'b1; req_va = va; req_acc = acc; req_user = user;
        @(negedge clk);
        req_valid = 1'b0;
        if (!hit) begin
            check(!rsp_valid && !req_ready, "R3",
                  $sformatf("stall cycle va=%h valid=%0b ready=%0b exp 0/0", va, rsp_valid, req_ready));
            @(negedge clk);
        end
        act = {rsp_valid, rsp_hit, rsp_fault, rsp_prot, rsp_pa};
        check(act == exp, req, $sformatf("va=%h acc=%0d user=%0b act=%h exp=%h", va, acc, user, act, exp));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog: run did not finish, act=timeout exp=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) m_pt[i] = '0;
        for (int s = 0; s < 4; s++) begin
            m_rr[s] = 0;
            for (int w = 0; w < 4; w++) begin m_v[s][w] = 1'b0; m_tag[s][w] = '0; m_pte[s][w] = '0; end
        end
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state, empty table faults.
        check(req_ready && !rsp_valid, "R9",
              $sformatf("ready=%0b valid=%0b exp 1/0", req_ready, rsp_valid));
        translate(14'h0040, 2'd0, 1'b0, "R9");

        // R1 R3 R2: miss then hit on same page.
        pt_write(8'h0F, mk(1, 0, 0, 1, 1, 6'h0D));
        translate(14'h03D4, 2'd0, 1'b1, "R1 R3");
        translate(14'h03C7, 2'd1, 1'b1, "R2");

        // R4: non-resident page faults and is not cached.
        translate(14'h02C5, 2'd0, 1'b0, "R4");
        translate(14'h02C5, 2'd0, 1'b0, "R4");

        // R5: permission and privilege refusals.
        pt_write(8'h20, mk(1, 0, 0, 0, 1, 6'h11));
        pt_write(8'h21, mk(1, 1, 1, 1, 1, 6'h22));
        translate(14'h0801, 2'd1, 1'b1, "R5");
        translate(14'h0802, 2'd0, 1'b1, "R5");
        translate(14'h0802, 2'd2, 1'b1, "R5");
        translate(14'h0843, 2'd0, 1'b1, "R5");
        translate(14'h0843, 2'd0, 1'b0, "R5");
        translate(14'h0844, 2'd3, 1'b0, "R5");

        // R6: five pages into one set, round-robin eviction.
        flush_tlb();
        for (int i = 0; i < 5; i++) pt_write(8'h40 + 8'(4 * i), mk(1, 0, 1, 1, 1, 6'(i + 1)));
        for (int i = 0; i < 4; i++) translate({8'h40 + 8'(4 * i), 6'h05}, 2'd0, 1'b0, "R6");
        for (int i = 0; i < 4; i++) translate({8'h40 + 8'(4 * i), 6'h06}, 2'd0, 1'b0, "R6");
        translate({8'h50, 6'h07}, 2'd0, 1'b0, "R6");
        translate({8'h44, 6'h08}, 2'd0, 1'b0, "R6");
        translate({8'h40, 6'h09}, 2'd0, 1'b0, "R6");
        translate({8'h44, 6'h0A}, 2'd0, 1'b0, "R6");

        // R7: flush forces a miss.
        translate(14'h03D0, 2'd0, 1'b0, "R7");
        flush_tlb();
        translate(14'h03D1, 2'd0, 1'b0, "R7");

        // R8: rewrite drops the cached copy.
        translate(14'h03D2, 2'd0, 1'b0, "R8");
        pt_write(8'h0F, mk(1, 0, 0, 1, 1, 6'h2A));
        translate(14'h03D3, 2'd0, 1'b0, "R8");
        translate(14'h03D4, 2'd0, 1'b0, "R8");

        // Random traffic over a small page range to mix hits and misses.
        for (int i = 0; i < 32; i++)
            pt_write(8'(i), mk(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                               1'($urandom), 6'($urandom)));
        for (int n = 0; n < 400; n++) begin
            int r = int'($urandom % 100);
            if (r < 8)
                pt_write(8'($urandom % 32), mk(1'($urandom), 1'($urandom), 1'($urandom),
                                               1'($urandom), 1'($urandom), 6'($urandom)));
            else if (r < 11)
                flush_tlb();
            else
                translate({8'($urandom % 32), 6'($urandom)}, 2'($urandom), 1'($urandom),
                          "R1 R2 R3 R6 random");
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule